// File: doc/BRIEF.md
# Idle and Slow-Idle Clock Enable Controller

This block parks a processor core in a low-power wait state and can also slow every clock that the core derives while it waits. An idle command drops the core's execute enable and holds it low until an interrupt arrives whose mask bit is set. Once such an interrupt arrives, the execute enable returns so that the interrupt can be serviced and the instruction after the idle command can run.

The idle command carries a slow flag and a 2-bit divisor code. With the flag clear, the wait is a standard idle: all derived clock enables stay high on every cycle, and wake-up follows one cycle after the interrupt. With the flag set, a free-running divide counter makes the core, serial, timer and clock-output enables pulse once every n base cycles, with n one of 16, 32, 64 or 128. Interrupts are then acted on only at a divided-clock boundary, so wake-up can take up to n cycles. Cycle-steal requests from the DMA and autobuffer paths are granted in every state and never end the wait.

Top module: `slowidle_ctrl`

## Requirements
- R1: After reset the execute enable and all four derived enables are high, the idle indicator is low and the DMA enable is low.
- R2: An idle command taken while running lowers the execute enable and raises the idle indicator from the next cycle.
- R3: While idle, a pending interrupt whose mask bit is clear has no effect: the block stays idle indefinitely.
- R4: In standard idle (slow flag 0), a pending unmasked interrupt raises the execute enable on the next cycle.
- R5: Outside slow idle, the core, serial, timer and clock-output enables are high on every cycle.
- R6: In slow idle the divisor code selects n: 00 gives 16, 01 gives 32, 10 gives 64 and 11 gives 128. The core enable pulses for one cycle every n cycles, and the first pulse comes n cycles after entry.
- R7: In slow idle the serial, timer and clock-output enables pulse in the same cycles as the core enable.
- R8: In slow idle an unmasked interrupt ends the wait only at a cycle where the core enable pulses. The execute enable rises on the following cycle, so the latency is at most n cycles. After that the enables run at full rate again.
- R9: Each cycle of cycle-steal request gives one cycle of DMA enable on the next cycle, and it does not change the idle state.
- R10: An idle command issued while already idle is ignored, and the divisor in use does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Idle command, one cycle |
| idle_slow | input | 1 | With idle_req: 1 selects slow idle |
| idle_div_sel | input | SEL_W | With idle_req: divisor code |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_mask | input | NIRQ | Interrupt enable mask, 1 = unmasked |
| steal_req | input | 1 | DMA or autobuffer cycle-steal request |
| exec_en | output | 1 | Core execute enable |
| idle_active | output | 1 | High while waiting in either idle form |
| core_ce | output | 1 | Core clock enable |
| sclk_ce | output | 1 | Serial clock enable |
| tmr_ce | output | 1 | Timer clock enable |
| clkout_ce | output | 1 | Clock-output enable |
| dma_ce | output | 1 | One-cycle enable for the cycle-steal path |

## Verification
The properties assume that idle_req is a single-cycle pulse and that the interrupt lines and mask stay stable between the bench's drive points. They also assume that each interrupt meant to wake the block is held until the execute enable rises. The bench changes inputs only at falling edges, and it keeps each waking interrupt asserted until it sees exec_en high before it clears the interrupt. Divisor codes cover all four values, and interrupts arrive both just after slow-idle entry and on a boundary cycle, which exercises the latency bound at its two ends.

// File: rtl/slowidle_pkg.sv
package slowidle_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_STD  = 2'd1,
        MODE_SLOW = 2'd2
    } idle_mode_e;

    // derived clock domains, index into the enable vector
    localparam int unsigned DOM_CORE  = 0;
    localparam int unsigned DOM_SER   = 1;
    localparam int unsigned DOM_TMR   = 2;
    localparam int unsigned DOM_OUT   = 3;
    localparam int unsigned DOM_COUNT = 4;

endpackage

// File: rtl/idle_seq.sv
module idle_seq
    import slowidle_pkg::*;
#(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_req,
    input  logic             enter_slow,
    input  logic [SEL_W-1:0] enter_sel,
    input  logic             wake_any,
    input  logic             div_tick,
    output idle_mode_e       mode,
    output logic [SEL_W-1:0] sel
);

    typedef struct packed {
        idle_mode_e       mode;
        logic [SEL_W-1:0] sel;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.mode)
            MODE_RUN: begin
                if (enter_req) begin
                    nxt_d.mode = enter_slow ? MODE_SLOW : MODE_STD;
                    nxt_d.sel  = enter_sel;
                end
            end
            MODE_STD: begin
                if (wake_any) nxt_d.mode = MODE_RUN;
            end
            MODE_SLOW: begin
                // only act on a divided-clock boundary
                if (div_tick && wake_any) nxt_d.mode = MODE_RUN;
            end
            default: nxt_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.mode <= MODE_RUN;
            cur_q.sel  <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mode = cur_q.mode;
    assign sel  = cur_q.sel;

endmodule

// File: rtl/slow_divider.sv
module slow_divider #(
    parameter int unsigned DIV_LOG2 = 4,
    parameter int unsigned SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int unsigned CNT_W = DIV_LOG2 + (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t div_q, div_d;
    logic [CNT_W-1:0] last_d;
    logic             tick_d;

    always_comb begin
        last_d = CNT_W'((32'd1 << (DIV_LOG2 + 32'(sel))) - 32'd1);
        tick_d = active && (div_q.cnt == last_d);
        div_d  = div_q;
        if (!active || tick_d) div_d.cnt = '0;
        else                   div_d.cnt = div_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q.cnt <= '0;
        else        div_q     <= div_d;
    end

    assign tick = tick_d;

endmodule

// File: rtl/ce_fanout.sv
module ce_fanout
    import slowidle_pkg::*;
#(
    parameter int unsigned NDOM = DOM_COUNT
) (
    input  idle_mode_e      mode,
    input  logic            tick,
    output logic [NDOM-1:0] ce
);

    genvar g;
    generate
        for (g = 0; g < NDOM; g++) begin : g_dom
            assign ce[g] = (mode != MODE_SLOW) || tick;
        end
    endgenerate

endmodule

// File: rtl/slowidle_ctrl.sv
module slowidle_ctrl
    import slowidle_pkg::*;
#(
    parameter int unsigned NIRQ     = 8,
    parameter int unsigned DIV_LOG2 = 4,
    parameter int unsigned SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_req,
    input  logic             idle_slow,
    input  logic [SEL_W-1:0] idle_div_sel,
    input  logic [NIRQ-1:0]  irq_pend,
    input  logic [NIRQ-1:0]  irq_mask,
    input  logic             steal_req,
    output logic             exec_en,
    output logic             idle_active,
    output logic             core_ce,
    output logic             sclk_ce,
    output logic             tmr_ce,
    output logic             clkout_ce,
    output logic             dma_ce
);

    typedef struct packed {
        logic dma;
    } top_t;

    idle_mode_e          mode;
    logic [SEL_W-1:0]    sel;
    logic                wake_any;
    logic                div_tick;
    logic [DOM_COUNT-1:0] dom_ce;
    top_t                top_q, top_d;

    assign wake_any = |(irq_pend & irq_mask);

    idle_seq #(.SEL_W(SEL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_req  (idle_req),
        .enter_slow (idle_slow),
        .enter_sel  (idle_div_sel),
        .wake_any   (wake_any),
        .div_tick   (div_tick),
        .mode       (mode),
        .sel        (sel)
    );

    slow_divider #(.DIV_LOG2(DIV_LOG2), .SEL_W(SEL_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (mode == MODE_SLOW),
        .sel    (sel),
        .tick   (div_tick)
    );

    ce_fanout #(.NDOM(DOM_COUNT)) u_ce (
        .mode (mode),
        .tick (div_tick),
        .ce   (dom_ce)
    );

    always_comb begin
        top_d     = top_q;
        top_d.dma = steal_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q.dma <= 1'b0;
        else        top_q     <= top_d;
    end

    assign exec_en     = (mode == MODE_RUN);
    assign idle_active = (mode != MODE_RUN);
    assign core_ce     = dom_ce[DOM_CORE];
    assign sclk_ce     = dom_ce[DOM_SER];
    assign tmr_ce      = dom_ce[DOM_TMR];
    assign clkout_ce   = dom_ce[DOM_OUT];
    assign dma_ce      = top_q.dma;

endmodule

// File: rtl/slowidle_chk.sv
module slowidle_chk
    import slowidle_pkg::*;
#(
    parameter int unsigned NIRQ     = 8,
    parameter int unsigned DIV_LOG2 = 4,
    parameter int unsigned SEL_W    = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            idle_req,
    input logic [NIRQ-1:0] irq_pend,
    input logic [NIRQ-1:0] irq_mask,
    input logic            steal_req,
    input logic            exec_en,
    input logic            idle_active,
    input logic            core_ce,
    input logic            sclk_ce,
    input logic            tmr_ce,
    input logic            clkout_ce,
    input logic            dma_ce,
    input idle_mode_e      mode
);

    localparam int unsigned MAX_DIV = 1 << (DIV_LOG2 + (1 << SEL_W) - 1);
    localparam int unsigned GAP_W   = DIV_LOG2 + (1 << SEL_W) + 1;

    logic            irq_any;
    logic [GAP_W-1:0] gap_q;

    assign irq_any = |(irq_pend & irq_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             gap_q <= '0;
        else if (mode == MODE_SLOW && !core_ce) gap_q <= gap_q + 1'b1;
        else                                    gap_q <= '0;
    end

    // R2
    enter_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_active && idle_req) |=> (!exec_en && idle_active));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_active && !irq_any) |=> idle_active);

    // R4
    std_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STD && irq_any) |=> exec_en);

    // R5
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_SLOW) |-> (core_ce && sclk_ce && tmr_ce && clkout_ce));

    // R6
    slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < GAP_W'(MAX_DIV));

    // R7
    same_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_ce == core_ce) && (tmr_ce == core_ce) && (clkout_ce == core_ce));

    // R8
    slow_wake_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(exec_en) && $past(mode) == MODE_SLOW) |-> $past(core_ce));

    // R9
    steal_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        steal_req |=> dma_ce);

endmodule

bind slowidle_ctrl slowidle_chk #(
    .NIRQ(NIRQ), .DIV_LOG2(DIV_LOG2), .SEL_W(SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req    (idle_req),
    .irq_pend    (irq_pend),
    .irq_mask    (irq_mask),
    .steal_req   (steal_req),
    .exec_en     (exec_en),
    .idle_active (idle_active),
    .core_ce     (core_ce),
    .sclk_ce     (sclk_ce),
    .tmr_ce      (tmr_ce),
    .clkout_ce   (clkout_ce),
    .dma_ce      (dma_ce),
    .mode        (mode)
);

// File: tb/sim_slowidle_ctrl.sv
module sim_slowidle_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_req = 1'b0;
    logic       idle_slow = 1'b0;
    logic [1:0] idle_div_sel = 2'b00;
    logic [7:0] irq_pend = '0;
    logic [7:0] irq_mask = '0;
    logic       steal_req = 1'b0;
    logic       exec_en, idle_active, core_ce, sclk_ce, tmr_ce, clkout_ce, dma_ce;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slowidle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_slow(idle_slow),
        .idle_div_sel(idle_div_sel), .irq_pend(irq_pend), .irq_mask(irq_mask),
        .steal_req(steal_req), .exec_en(exec_en), .idle_active(idle_active),
        .core_ce(core_ce), .sclk_ce(sclk_ce), .tmr_ce(tmr_ce),
        .clkout_ce(clkout_ce), .dma_ce(dma_ce)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enter_idle(input logic slow, input logic [1:0] code);
        idle_req = 1'b1; idle_slow = slow; idle_div_sel = code;
        step();
        idle_req = 1'b0; idle_slow = 1'b0; idle_div_sel = 2'b00;
    endtask

    // raise an unmasked interrupt and return the cycles until exec_en is high
    task automatic wake_and_time(output int lat);
        irq_pend[3] = 1'b1; irq_mask[3] = 1'b1;
        lat = 0;
        do begin
            step();
            lat++;
        end while (!exec_en && lat < 400);
        irq_pend = '0; irq_mask = '0;
    endtask

    task automatic t_reset();
        check_eq("R1 exec_en", int'(exec_en), 1);
        check_eq("R1 idle_active", int'(idle_active), 0);
        check_eq("R1 enables", int'({core_ce, sclk_ce, tmr_ce, clkout_ce}), 15);
        check_eq("R1 dma_ce", int'(dma_ce), 0);
    endtask

    task automatic t_std_idle();
        int lat;
        int bad = 0;
        enter_idle(1'b0, 2'b00);
        check_eq("R2 exec_en low", int'(exec_en), 0);
        check_eq("R2 idle_active", int'(idle_active), 1);
        for (int i = 0; i < 6; i++) begin
            if ({core_ce, sclk_ce, tmr_ce, clkout_ce} != 4'hF) bad++;
            step();
        end
        check_eq("R5 full rate in std idle", bad, 0);
        wake_and_time(lat);
        check_eq("R4 std wake latency", lat, 1);
    endtask

    task automatic t_masked();
        int lat;
        int woke = 0;
        enter_idle(1'b0, 2'b00);
        irq_pend = 8'hFF; irq_mask = 8'h00;
        for (int i = 0; i < 300; i++) begin
            step();
            if (exec_en) woke++;
        end
        check_eq("R3 masked irq ignored", woke, 0);
        irq_pend = '0;
        wake_and_time(lat);
        check_eq("R4 wake after mask", lat, 1);
    endtask

    task automatic t_slow(input logic [1:0] code);
        int n = 16 << code;
        int pulses = 0;
        int first = -1;
        int second = -1;
        int mism = 0;
        int lat;
        enter_idle(1'b1, code);
        check_eq("R2 slow entry exec_en", int'(exec_en), 0);
        for (int k = 0; k < 2 * n; k++) begin
            if (core_ce) begin
                pulses++;
                if (first < 0) first = k; else if (second < 0) second = k;
            end
            if (sclk_ce != core_ce || tmr_ce != core_ce || clkout_ce != core_ce) mism++;
            step();
        end
        check_eq($sformatf("R6 pulses n=%0d", n), pulses, 2);
        check_eq($sformatf("R6 first pulse n=%0d", n), first + 1, n);
        check_eq($sformatf("R6 spacing n=%0d", n), second - first, n);
        check_eq($sformatf("R7 same ratio n=%0d", n), mism, 0);
        wake_and_time(lat);
        check_eq($sformatf("R8 slow wake latency n=%0d", n), lat, n);
        check_eq("R8 full rate after wake", int'({core_ce, sclk_ce, tmr_ce, clkout_ce}), 15);
    endtask

    task automatic t_slow_boundary();
        int lat;
        enter_idle(1'b1, 2'b00);
        for (int k = 0; k < 15; k++) step();
        check_eq("R8 at boundary", int'(core_ce), 1);
        wake_and_time(lat);
        check_eq("R8 boundary wake latency", lat, 1);
    endtask

    task automatic t_steal();
        int lat;
        enter_idle(1'b0, 2'b00);
        steal_req = 1'b1;
        step();
        steal_req = 1'b0;
        check_eq("R9 dma_ce granted", int'(dma_ce), 1);
        check_eq("R9 still idle", int'(idle_active), 1);
        step();
        check_eq("R9 dma_ce one cycle", int'(dma_ce), 0);
        check_eq("R9 exec_en low", int'(exec_en), 0);
        wake_and_time(lat);
        enter_idle(1'b1, 2'b01);
        steal_req = 1'b1;
        step();
        steal_req = 1'b0;
        check_eq("R9 dma_ce in slow idle", int'(dma_ce), 1);
        check_eq("R9 slow still idle", int'(idle_active), 1);
        wake_and_time(lat);
    endtask

    task automatic t_ignore();
        int gap = 0;
        int lat;
        int full = 0;
        enter_idle(1'b1, 2'b00);
        step(); step();
        idle_req = 1'b1; idle_slow = 1'b0; idle_div_sel = 2'b11;
        step();
        idle_req = 1'b0; idle_div_sel = 2'b00;
        while (!core_ce && gap < 300) begin step(); gap++; end
        step();
        gap = 1;
        while (!core_ce && gap < 300) begin
            if (exec_en) full++;
            step();
            gap++;
        end
        check_eq("R10 divisor kept", gap, 16);
        check_eq("R10 still idle", int'(idle_active) + full, 1);
        wake_and_time(lat);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_std_idle();
        t_masked();
        for (int c = 0; c < 4; c++) t_slow(2'(c));
        t_slow_boundary();
        t_steal();
        t_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule